// File: doc/BRIEF.md
# Masked BAR Window Decoder

This block keeps the base registers for three address windows and decides, for any system address, which of them it falls in. Two windows are MMIO windows, each described by a base register and a mask register. The third is a register window with a fixed span of 4 KiB. A separate enable register switches each window on or off. Software reaches the six registers through a 64-bit access port that only takes whole, aligned doublewords. A lookup port takes an address and returns, one cycle later, a per-window hit vector, an overall hit flag and the identifier of the winning window.

Every register write is trimmed to the bits that register implements. A window's base is its register value shifted right by 14. An MMIO window's size is the inverse of its mask, shifted right by 14, plus one. Software mistakes are reported on two one-cycle pulses. One reports a malformed or unknown access. The other reports a rewrite of a window's base or mask while that window is live. The rewrite still takes effect. Routing traffic into the windows belongs to the surrounding logic.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset, each register reads back its parameter reset value with the write trimming of R3, R4 and R5 applied. The default enable value is zero.
- R2: The register index is the byte address shifted right by 3. Index 0 is MMIO base 0, index 1 is MMIO base 1, index 2 is MMIO mask 0, index 3 is MMIO mask 1, index 4 is the register-window base and index 5 is the enable register. A good read returns `rd_valid` high and the data on `rd_data` in the cycle after the request. Bit 63 is the most significant bit.
- R3: A write to an MMIO base or MMIO mask stores bits 63:30 and clears bits 29:0.
- R4: A write to the register-window base stores bits 63:26 and clears bits 25:0.
- R5: A write to the enable register stores bits 63:59 and clears the rest. Bit 63 enables MMIO window 0, bit 62 enables MMIO window 1 and bit 61 enables the register window.
- R6: A window's base is its base register shifted right by 14. An MMIO window's size is (~mask >> 14) + 1. An address hits when base <= address < base + size.
- R7: The register window spans exactly 4096 addresses from its base, whatever value its register holds.
- R8: A window hits only while its enable bit is set. A lookup issued in any cycle after the enable write sees the new enable state.
- R9: Writing a base or mask of a window whose enable bit is set pulses `err_live_bar` in the next cycle, and the new value is still stored. The same write to a disabled window does not pulse the flag.
- R10: An access to an index above 5, or an access that is not 8 bytes wide at an 8-byte-aligned address, pulses `err_access` in the next cycle. No register changes and no read data is returned.
- R11: `lk_done` goes high in the cycle after `lk_valid`. It comes with `lk_hit_vec` (bit i for window i), `lk_hit` as the OR of that vector, and `lk_win` holding the lowest-numbered window that hits, or 3 when none hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ACC_AW | Byte address of the access |
| req_bytes | input | 4 | Access width in bytes |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| err_access | output | 1 | Malformed or unknown access pulse |
| err_live_bar | output | 1 | Write to an enabled window's base or mask pulse |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64-14 | System address to decode |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Any window hit |
| lk_hit_vec | output | 3 | Per-window hit flags |
| lk_win | output | 2 | Lowest-numbered window hit, 3 if none |

## Verification
The assertions check the rules that hold on every cycle. These are the read and lookup latency, the cleared low bits of the enable register, the pulse timing of both error flags, the rule that a hit needs the window's enable bit in the previous cycle, the 4 KiB span of the register window, and the agreement between the hit flag and the window identifier. Only the bench scenarios can show the arithmetic values. These are the trimmed contents after each write, the derived bases and sizes at both edges of each window, the priority between overlapping windows, and the register contents left unchanged after a rejected access.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int REG_W      = 64;
  localparam int BASE_SHIFT = 14;
  localparam int NUM_WIN    = 3;
  localparam int NUM_REGS   = 6;

  localparam int IDX_MBAR0 = 0;
  localparam int IDX_MBAR1 = 1;
  localparam int IDX_MMSK0 = 2;
  localparam int IDX_MMSK1 = 3;
  localparam int IDX_RBAR  = 4;
  localparam int IDX_ENA   = 5;

  localparam logic [REG_W-1:0] KEEP_MMIO = 64'hFFFF_FFFF_C000_0000;
  localparam logic [REG_W-1:0] KEEP_RBAR = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [REG_W-1:0] KEEP_ENA  = 64'hF800_0000_0000_0000;

  localparam logic [1:0] WIN_NONE = 2'd3;

  function automatic logic [REG_W-1:0] keep_for(input int k);
    case (k)
      IDX_RBAR: keep_for = KEEP_RBAR;
      IDX_ENA:  keep_for = KEEP_ENA;
      default:  keep_for = KEEP_MMIO;
    endcase
  endfunction
endpackage

// File: rtl/bwd_regfile.sv
module bwd_regfile
  import bwd_pkg::*;
#(
  parameter int               ACC_AW    = 6,
  parameter logic [REG_W-1:0] RST_MBAR0 = 64'h0,
  parameter logic [REG_W-1:0] RST_MBAR1 = 64'h0,
  parameter logic [REG_W-1:0] RST_MMSK0 = 64'h0,
  parameter logic [REG_W-1:0] RST_MMSK1 = 64'h0,
  parameter logic [REG_W-1:0] RST_RBAR  = 64'h0,
  parameter logic [REG_W-1:0] RST_ENA   = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ACC_AW-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic              err_access,
  output logic              err_live_bar,
  output logic [REG_W-1:0]  mbar0,
  output logic [REG_W-1:0]  mbar1,
  output logic [REG_W-1:0]  mmsk0,
  output logic [REG_W-1:0]  mmsk1,
  output logic [REG_W-1:0]  rbar,
  output logic [REG_W-1:0]  ena
);
  localparam int IW = ACC_AW - 3;

  function automatic logic [REG_W-1:0] rst_for(input int k);
    case (k)
      IDX_MBAR0: rst_for = RST_MBAR0;
      IDX_MBAR1: rst_for = RST_MBAR1;
      IDX_MMSK0: rst_for = RST_MMSK0;
      IDX_MMSK1: rst_for = RST_MMSK1;
      IDX_RBAR:  rst_for = RST_RBAR;
      default:   rst_for = RST_ENA;
    endcase
  endfunction

  logic [REG_W-1:0]    regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] wr_en;
  logic [IW-1:0]       idx;
  logic                shape_ok, known, wr_ok;
  logic                live_d, bad_d, rdv_d;
  logic [REG_W-1:0]    rd_sel;

  always_comb begin
    idx      = req_addr[ACC_AW-1:3];
    shape_ok = (req_bytes == 4'd8) && (req_addr[2:0] == 3'b000);
    known    = (idx < IW'(NUM_REGS));
    wr_ok    = req_valid && req_write && shape_ok && known;
    bad_d    = req_valid && !(shape_ok && known);
    rdv_d    = req_valid && !req_write && shape_ok && known;
    rd_sel   = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      wr_en[k] = wr_ok && (idx == IW'(k));
      if (idx == IW'(k)) rd_sel = regs_q[k];
    end
    // a base or mask is live when its own window's enable bit is set
    live_d = 1'b0;
    if (wr_ok) begin
      if (idx == IW'(IDX_MBAR0) || idx == IW'(IDX_MMSK0)) live_d = regs_q[IDX_ENA][63];
      if (idx == IW'(IDX_MBAR1) || idx == IW'(IDX_MMSK1)) live_d = regs_q[IDX_ENA][62];
      if (idx == IW'(IDX_RBAR))                           live_d = regs_q[IDX_ENA][61];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= rst_for(k) & keep_for(k);
    end else begin
      for (int k = 0; k < NUM_REGS; k++)
        if (wr_en[k]) regs_q[k] <= req_wdata & keep_for(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      err_access   <= 1'b0;
      err_live_bar <= 1'b0;
    end else begin
      rd_valid     <= rdv_d;
      err_access   <= bad_d;
      err_live_bar <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rdv_d) rd_data <= rd_sel;
  end

  assign mbar0 = regs_q[IDX_MBAR0];
  assign mbar1 = regs_q[IDX_MBAR1];
  assign mmsk0 = regs_q[IDX_MMSK0];
  assign mmsk1 = regs_q[IDX_MMSK1];
  assign rbar  = regs_q[IDX_RBAR];
  assign ena   = regs_q[IDX_ENA];

  // R2: a well-formed read answers in the next cycle
  p_rd_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_bytes == 4'd8 && req_addr[2:0] == 3'b000
     && idx < IW'(NUM_REGS)) |=> rd_valid);
  // R10: a malformed access raises the flag and yields no data
  p_bad_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bytes != 4'd8) |=> (err_access && !rd_valid));
  // R5: the enable register never holds bits below 59
  p_ena_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ena[58:0] == '0);
  // R9: the live-rewrite flag only follows a write request
  p_live_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_live_bar |-> $past(req_valid && req_write));
endmodule

// File: rtl/bwd_window.sv
module bwd_window
  import bwd_pkg::*;
#(
  parameter bit FIXED      = 1'b0,
  parameter int FIXED_SIZE = 4096,
  parameter int SYS_W      = REG_W - BASE_SHIFT
) (
  input  logic [REG_W-1:0] bar,
  input  logic [REG_W-1:0] msk,
  input  logic             en,
  input  logic [SYS_W-1:0] addr,
  output logic             hit
);
  logic [SYS_W-1:0] base;
  logic [SYS_W:0]   size;
  logic [SYS_W:0]   limit;
  logic             unused_bits;

  assign base = bar[REG_W-1:BASE_SHIFT];

  generate
    if (FIXED) begin : g_fixed
      assign size        = (SYS_W+1)'(FIXED_SIZE);
      assign unused_bits = ^{msk, bar[BASE_SHIFT-1:0]};
    end else begin : g_masked
      assign size        = {1'b0, ~msk[REG_W-1:BASE_SHIFT]} + (SYS_W+1)'(1);
      assign unused_bits = ^{msk[BASE_SHIFT-1:0], bar[BASE_SHIFT-1:0]};
    end
  endgenerate

  always_comb begin
    limit = {1'b0, base} + size;
    hit   = en && (addr >= base) && ({1'b0, addr} < limit);
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bwd_pkg::*;
#(
  parameter int               ACC_AW      = 6,
  parameter int               REGWIN_SIZE = 4096,
  parameter logic [REG_W-1:0] RST_MBAR0   = 64'h0000_1000_0000_0000,
  parameter logic [REG_W-1:0] RST_MBAR1   = 64'h0000_2000_0000_0000,
  parameter logic [REG_W-1:0] RST_MMSK0   = 64'hFFFF_FFFF_C000_0000,
  parameter logic [REG_W-1:0] RST_MMSK1   = 64'hFFFF_FFFF_0000_0000,
  parameter logic [REG_W-1:0] RST_RBAR    = 64'h0000_3000_0000_0000,
  parameter logic [REG_W-1:0] RST_ENA     = 64'h0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ACC_AW-1:0]             req_addr,
  input  logic [3:0]                    req_bytes,
  input  logic [REG_W-1:0]              req_wdata,
  output logic                          rd_valid,
  output logic [REG_W-1:0]              rd_data,
  output logic                          err_access,
  output logic                          err_live_bar,
  input  logic                          lk_valid,
  input  logic [REG_W-BASE_SHIFT-1:0]   lk_addr,
  output logic                          lk_done,
  output logic                          lk_hit,
  output logic [NUM_WIN-1:0]            lk_hit_vec,
  output logic [1:0]                    lk_win
);
  localparam int SYS_W = REG_W - BASE_SHIFT;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [REG_W-1:0] mbar0_w, mbar1_w, mmsk0_w, mmsk1_w, rbar_w, ena_w;

  bwd_regfile #(
    .ACC_AW(ACC_AW), .RST_MBAR0(RST_MBAR0), .RST_MBAR1(RST_MBAR1),
    .RST_MMSK0(RST_MMSK0), .RST_MMSK1(RST_MMSK1), .RST_RBAR(RST_RBAR),
    .RST_ENA(RST_ENA)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_access(err_access),
    .err_live_bar(err_live_bar), .mbar0(mbar0_w), .mbar1(mbar1_w),
    .mmsk0(mmsk0_w), .mmsk1(mmsk1_w), .rbar(rbar_w), .ena(ena_w)
  );

  logic [REG_W-1:0]   bar_a [NUM_WIN];
  logic [REG_W-1:0]   msk_a [NUM_WIN];
  logic [NUM_WIN-1:0] hit_d;
  logic [1:0]         win_d;
  logic               unused_ena;

  assign bar_a[0] = mbar0_w;
  assign bar_a[1] = mbar1_w;
  assign bar_a[2] = rbar_w;
  assign msk_a[0] = mmsk0_w;
  assign msk_a[1] = mmsk1_w;
  assign msk_a[2] = '0;
  assign unused_ena = ^ena_w[60:0];

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      bwd_window #(
        .FIXED(w == NUM_WIN-1), .FIXED_SIZE(REGWIN_SIZE), .SYS_W(SYS_W)
      ) i_win (
        .bar(bar_a[w]), .msk(msk_a[w]), .en(ena_w[REG_W-1-w]),
        .addr(lk_addr), .hit(hit_d[w])
      );
    end
  endgenerate

  always_comb begin
    win_d = WIN_NONE;
    for (int w = NUM_WIN-1; w >= 0; w--)
      if (hit_d[w]) win_d = 2'(w);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lk_done <= 1'b0;
    else             lk_done <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lk_hit_vec <= '0;
      lk_hit     <= 1'b0;
      lk_win     <= WIN_NONE;
    end else if (lk_valid) begin
      lk_hit_vec <= hit_d;
      lk_hit     <= |hit_d;
      lk_win     <= win_d;
    end
  end

  // R11: result one cycle after the request
  p_lookup_lat_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> lk_done);
  // R11: hit flag agrees with the window identifier
  p_id_match_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_done |-> (lk_hit == (lk_win != WIN_NONE)));
  // R8: a window can only hit while it was enabled
  p_hit_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_done && lk_hit_vec[0]) |-> $past(ena_w[63]));
  // R7: register-window hits stay within its fixed span
  p_regwin_span_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_done && lk_hit_vec[2]) |->
      (($past(lk_addr) - $past(rbar_w[REG_W-1:BASE_SHIFT])) < SYS_W'(REGWIN_SIZE)));
endmodule

// File: tb/test_bar_window_decoder.sv
`timescale 1ns/1ps
module test_bar_window_decoder;
  localparam int SW = 50;
  localparam logic [63:0] K_MMIO = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] K_RBAR = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [63:0] K_ENA  = 64'hF800_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [5:0] req_addr;
  logic [3:0] req_bytes;
  logic [63:0] req_wdata;
  logic rd_valid, err_access, err_live_bar;
  logic [63:0] rd_data;
  logic lk_valid, lk_done, lk_hit;
  logic [SW-1:0] lk_addr;
  logic [2:0] lk_hit_vec;
  logic [1:0] lk_win;

  int n_chk = 0, n_fail = 0;
  logic [63:0] sh [6];

  always #5 clk = ~clk;

  bar_window_decoder i_bar_window_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_access(err_access),
    .err_live_bar(err_live_bar), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_hit_vec(lk_hit_vec), .lk_win(lk_win)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] keep(input int k);
    if (k == 4) return K_RBAR;
    if (k == 5) return K_ENA;
    return K_MMIO;
  endfunction

  function automatic logic [63:0] bar_of(input logic [SW-1:0] base);
    return {base, 14'b0};
  endfunction

  // expected hit vector from the shadow copy using the stated formulas
  function automatic logic [2:0] exp_vec(input logic [SW-1:0] a);
    logic [2:0] v;
    for (int w = 0; w < 3; w++) begin
      logic [SW-1:0] b;
      logic [SW:0] s;
      b = sh[w == 2 ? 4 : w][63:14];
      s = (w == 2) ? (SW+1)'(4096) : {1'b0, ~sh[w + 2][63:14]} + 1;
      v[w] = sh[5][63 - w] && (a >= b) && ({1'b0, a} < {1'b0, b} + s);
    end
    return v;
  endfunction

  task automatic access(input logic wr, input logic [5:0] a, input logic [63:0] d,
                        input logic [3:0] nb, output logic rv, output logic [63:0] rdat,
                        output logic ea, output logic el);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bytes = nb;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rv = rd_valid; rdat = rd_data; ea = err_access; el = err_live_bar;
    if (wr && nb == 4'd8 && a[2:0] == 3'd0 && a[5:3] < 3'd6)
      sh[a[5:3]] = d & keep(int'(a[5:3]));
  endtask

  task automatic wr_reg(input int k, input logic [63:0] d, output logic el);
    logic rv, ea; logic [63:0] rdat;
    access(1'b1, 6'(k * 8), d, 4'd8, rv, rdat, ea, el);
  endtask

  task automatic rd_reg(input int k, output logic [63:0] v);
    logic rv, ea, el;
    access(1'b0, 6'(k * 8), 64'h0, 4'd8, rv, v, ea, el);
    chk("R2 read valid", 64'(rv), 64'd1);
  endtask

  task automatic look(input string rq, input logic [SW-1:0] a);
    logic [2:0] ev; logic [1:0] ew;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    ev = exp_vec(a);
    ew = ev[0] ? 2'd0 : ev[1] ? 2'd1 : ev[2] ? 2'd2 : 2'd3;
    chk({rq, " R11 done"}, 64'(lk_done), 64'd1);
    chk({rq, " hit vector"}, 64'(lk_hit_vec), 64'(ev));
    chk({rq, " R11 hit"}, 64'(lk_hit), 64'(|ev));
    chk({rq, " R11 window id"}, 64'(lk_win), 64'(ew));
  endtask

  task automatic t_reset;
    logic [63:0] v;
    sh[0] = 64'h0000_1000_0000_0000; sh[1] = 64'h0000_2000_0000_0000;
    sh[2] = 64'hFFFF_FFFF_C000_0000; sh[3] = 64'hFFFF_FFFF_0000_0000;
    sh[4] = 64'h0000_3000_0000_0000; sh[5] = 64'h0;
    chk("R1 no read after reset", 64'(rd_valid), 64'd0);
    chk("R11 idle window id", 64'(lk_win), 64'd3);
    for (int k = 0; k < 6; k++) begin
      rd_reg(k, v);
      chk("R1 reset value", v, sh[k]);
    end
  endtask

  task automatic t_decode;
    logic el;
    wr_reg(5, 64'hE000_0000_0000_0000, el);
    look("R6 win0 base", 50'h4000_0000);
    look("R6 win0 last", 50'h4000_FFFF);
    chk("R6 win0 last hits", 64'(lk_hit_vec), 64'd1);
    look("R6 win0 end", 50'h4001_0000);
    look("R6 below win0", 50'h3FFF_FFFF);
    look("R6 win1 last", 50'h8003_FFFF);
    chk("R6 win1 last hits", 64'(lk_hit_vec), 64'd2);
    look("R6 win1 end", 50'h8004_0000);
    look("R7 regwin last", 50'hC000_0FFF);
    chk("R7 regwin last hits", 64'(lk_hit_vec), 64'd4);
    look("R7 regwin end", 50'hC000_1000);
    chk("R7 regwin end misses", 64'(lk_hit), 64'd0);
  endtask

  task automatic t_masking;
    logic el; logic [63:0] v;
    logic [63:0] keep_sh [6];
    wr_reg(5, 64'h0, el);
    for (int k = 0; k < 6; k++) keep_sh[k] = sh[k];
    wr_reg(0, 64'hFFFF_FFFF_FFFF_FFFF, el);
    chk("R9 no error while disabled", 64'(el), 64'd0);
    rd_reg(0, v); chk("R3 mmio base trim", v, 64'hFFFF_FFFF_C000_0000);
    wr_reg(3, 64'h1234_5678_FFFF_FFFF, el);
    rd_reg(3, v); chk("R3 mmio mask trim", v, 64'h1234_5678_C000_0000);
    wr_reg(4, 64'hFFFF_FFFF_FFFF_FFFF, el);
    rd_reg(4, v); chk("R4 regwin base trim", v, 64'hFFFF_FFFF_FC00_0000);
    wr_reg(5, 64'hFFFF_FFFF_FFFF_FFFF, el);
    rd_reg(5, v); chk("R5 enable trim", v, 64'hF800_0000_0000_0000);
    wr_reg(5, 64'h0, el);
    for (int k = 0; k < 5; k++) wr_reg(k, keep_sh[k], el);
  endtask

  task automatic t_live;
    logic el; logic [63:0] v;
    wr_reg(5, 64'h8000_0000_0000_0000, el);
    wr_reg(0, bar_of(50'h1_0000_0000), el);
    chk("R9 live base rewrite flagged", 64'(el), 64'd1);
    rd_reg(0, v); chk("R9 rewrite stored", v, bar_of(50'h1_0000_0000));
    look("R9 new base decodes", 50'h1_0000_0010);
    chk("R9 new base hits", 64'(lk_hit_vec), 64'd1);
    wr_reg(2, 64'hFFFF_FFFF_C000_0000, el);
    chk("R9 live mask rewrite flagged", 64'(el), 64'd1);
    wr_reg(1, 64'h0000_2000_0000_0000, el);
    chk("R9 disabled window no flag", 64'(el), 64'd0);
  endtask

  task automatic t_disable;
    logic el;
    wr_reg(5, 64'h0, el);
    look("R8 all disabled", 50'h1_0000_0010);
    chk("R8 disabled misses", 64'(lk_hit), 64'd0);
    wr_reg(5, 64'h4000_0000_0000_0000, el);
    look("R8 win1 only", 50'h8000_0100);
    look("R8 win0 off", 50'h1_0000_0010);
    chk("R8 win0 off misses", 64'(lk_hit_vec), 64'd0);
  endtask

  task automatic t_bad;
    logic rv, ea, el; logic [63:0] rdat, v;
    access(1'b1, 6'h30, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8, rv, rdat, ea, el);
    chk("R10 unknown write flagged", 64'(ea), 64'd1);
    access(1'b0, 6'h38, 64'h0, 4'd8, rv, rdat, ea, el);
    chk("R10 unknown read flagged", 64'(ea), 64'd1);
    chk("R10 unknown read no data", 64'(rv), 64'd0);
    access(1'b1, 6'h08, 64'hFFFF_FFFF_FFFF_FFFF, 4'd4, rv, rdat, ea, el);
    chk("R10 narrow write flagged", 64'(ea), 64'd1);
    access(1'b1, 6'h0C, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8, rv, rdat, ea, el);
    chk("R10 misaligned flagged", 64'(ea), 64'd1);
    rd_reg(1, v); chk("R10 rejected writes left base", v, sh[1]);
    access(1'b0, 6'h08, 64'h0, 4'd8, rv, rdat, ea, el);
    chk("R2 good read no error", 64'(ea), 64'd0);
  endtask

  task automatic t_priority;
    logic el;
    wr_reg(5, 64'h0, el);
    wr_reg(0, bar_of(50'h4000_0000), el);
    wr_reg(4, bar_of(50'h4000_1000), el);
    wr_reg(5, 64'hE000_0000_0000_0000, el);
    look("R11 overlap", 50'h4000_1800);
    chk("R11 overlap both hit", 64'(lk_hit_vec), 64'd5);
    chk("R11 lowest wins", 64'(lk_win), 64'd0);
    look("R11 no window", 50'h2_0000_0000);
    chk("R11 miss id", 64'(lk_win), 64'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_bytes = 4'd8; req_wdata = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_decode;
    t_masking;
    t_live;
    t_disable;
    t_bad;
    t_priority;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule